// File: doc/BRIEF.md
# Compare-and-terminate loop flag unit

This unit is the execute slice for the 32-bit instruction that closes a serialized vector loop. Each cycle it may accept one instruction word. It checks the word against the fixed opcode pattern and reads two scalar operands from a small general register file. It compares the operands for equality or for inequality, at 32-bit or 64-bit width. It then writes a held NZCV flag register so that a later conditional instruction can choose between three outcomes. Those outcomes are: keep looping, stop because the compare matched, or stop because the previous predicate step already selected the last element.

The carry flag carries the "not last element" indication from earlier predicate work. Z and C pass through unchanged, and only N and V are rewritten. A word that does not decode, or any word issued while the vector extension is disabled, raises an undefined strobe and leaves the flags alone. The bench uses a synchronous write port to preload the register file. A separate flag load port lets the flag register be seeded, as the omitted predicate instructions would do.

Top module: `loop_exit_flags`

## Requirements
- R1: After reset, the flag outputs read 4'b0000 (bit order N,Z,C,V from bit 3 down to bit 0) and `undef_o` is low.
- R2: A word is accepted only when bits [31:30]=00, [29:24]=100101, bit 23=1, bit 21=1, [15:10]=001000 and [3:0]=0000. Any other word issued with `in_valid` high sets `undef_o` for the following cycle and leaves the flags unchanged.
- R3: When `vec_en` is low, a word issued with `in_valid` high sets `undef_o` for the following cycle and leaves the flags unchanged, whether or not the word matches.
- R4: Bit 4 of the word selects the test: 0 means "operands equal" and 1 means "operands differ". When the test holds, the next flags have N=1 and V=0.
- R5: When the test fails, the next flags have N=0 and V equal to the inverse of the C flag held before the update.
- R6: An accepted instruction keeps Z and C unchanged and never produces N=1 together with V=1.
- R7: Bit 22 selects the width. 0 compares only bits [31:0] of both operands, so bits [63:32] are ignored. 1 compares all 64 bits as unsigned patterns.
- R8: Bits [9:5] select the first operand and bits [20:16] select the second. Index 31 always reads as zero, and a register-file write to index 31 has no effect.
- R9: With `in_valid` and `flag_wr` low, the flags hold and `undef_o` stays low.
- R10: When `flag_wr` is high, the flags take `flag_wdata` at the next edge. This load wins over an instruction issued in the same cycle, although that instruction still raises `undef_o` if R2 or R3 applies.
- R11: A register-file write is visible to an instruction issued in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flag register and strobe |
| vec_en | input | 1 | Vector extension enabled |
| in_valid | input | 1 | An instruction word is issued this cycle |
| instr | input | 32 | Instruction word |
| rf_we | input | 1 | Register-file write enable |
| rf_waddr | input | 5 | Register-file write index |
| rf_wdata | input | 64 | Register-file write data |
| flag_wr | input | 1 | Flag register load enable |
| flag_wdata | input | 4 | Flag load value, {N,Z,C,V} |
| flags_o | output | 4 | Held flags, {N,Z,C,V} |
| undef_o | output | 1 | Undefined-instruction strobe |

## Verification
Both results are registered once. The flags and the undefined strobe for a word issued in one cycle therefore appear just after the next rising edge and last for exactly that cycle. The bench drives each stimulus on a falling edge and compares the outputs on the following falling edge, one full edge after the update. The bench keeps its own register-file image and flag state, so every expected value depends only on the stimulus history. Idle cycles are checked the same way, to confirm that the strobe drops again after one cycle.

// File: rtl/loop_exit_flags.sv
module loop_exit_flags #(
  parameter int XLEN = 64,
  parameter int IDXW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vec_en,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic            rf_we,
  input  logic [IDXW-1:0] rf_waddr,
  input  logic [XLEN-1:0] rf_wdata,
  input  logic            flag_wr,
  input  logic [3:0]      flag_wdata,
  output logic [3:0]      flags_o,
  output logic            undef_o
);
  localparam int HALF = XLEN / 2;
  localparam int DEPTH = 1 << IDXW;
  localparam logic [IDXW-1:0] ZIDX = IDXW'(DEPTH - 1);

  logic [XLEN-1:0] rf [DEPTH];
  logic [XLEN-1:0] opa, opb;
  logic [IDXW-1:0] ia, ib;
  logic            match, ok, same, hit;
  logic [3:0]      nxt;

  always_ff @(posedge clk)
    if (rf_we && rf_waddr != ZIDX) rf[rf_waddr] <= rf_wdata;

  assign ia = instr[9:5];
  assign ib = instr[20:16];
  assign opa = (ia == ZIDX) ? '0 : rf[ia];
  assign opb = (ib == ZIDX) ? '0 : rf[ib];

  assign match = instr[31:30] == 2'b00 && instr[29:24] == 6'b100101 &&
                 instr[23] && instr[21] && instr[15:10] == 6'b001000 &&
                 instr[3:0] == 4'b0000;
  assign ok = vec_en && match;

  assign same = instr[22] ? (opa == opb) : (opa[HALF-1:0] == opb[HALF-1:0]);
  assign hit  = same ^ instr[4];
  assign nxt  = {hit, flags_o[2], flags_o[1], ~hit & ~flags_o[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_o <= 4'b0000;
      undef_o <= 1'b0;
    end else begin
      undef_o <= in_valid && !ok;
      if (flag_wr)             flags_o <= flag_wdata;
      else if (in_valid && ok) flags_o <= nxt;
    end
  end
endmodule

module loop_exit_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vec_en,
  input logic       in_valid,
  input logic       flag_wr,
  input logic [3:0] flag_wdata,
  input logic [3:0] flags_o,
  input logic       undef_o
);
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> flags_o == $past(flag_wdata));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !flag_wr |=> !undef_o && $stable(flags_o));
  p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !vec_en && !flag_wr |=> undef_o && $stable(flags_o));
  p_zc_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !flag_wr |=> flags_o[2:1] == $past(flags_o[2:1]));
  p_no_nv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !flag_wr |=> undef_o || !(flags_o[3] && flags_o[0]));
  p_fail_v_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !flag_wr |=> undef_o || flags_o[3] || (flags_o[0] == !$past(flags_o[1])));
  p_undef_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o && !$past(flag_wr) |-> flags_o == $past(flags_o));
endmodule

bind loop_exit_flags loop_exit_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vec_en(vec_en), .in_valid(in_valid),
  .flag_wr(flag_wr), .flag_wdata(flag_wdata), .flags_o(flags_o), .undef_o(undef_o)
);

// File: tb/loop_exit_flags_bench.sv
`timescale 1ns/1ps
module loop_exit_flags_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        vec_en = 0;
  logic        in_valid = 0;
  logic [31:0] instr = '0;
  logic        rf_we = 0;
  logic [4:0]  rf_waddr = '0;
  logic [63:0] rf_wdata = '0;
  logic        flag_wr = 0;
  logic [3:0]  flag_wdata = '0;
  logic [3:0]  flags_o;
  logic        undef_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] m_rf [32];
  logic [3:0]  m_fl;

  always #4 clk = ~clk;

  loop_exit_flags u_loop_exit_flags (
    .clk(clk), .rst_n(rst_n), .vec_en(vec_en), .in_valid(in_valid), .instr(instr),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .flags_o(flags_o), .undef_o(undef_o)
  );

  function automatic logic [31:0] mk(input logic sz, input logic ne,
                                     input logic [4:0] rn, input logic [4:0] rm);
    return {2'b00, 6'b100101, 1'b1, sz, 1'b1, rm, 6'b001000, rn, ne, 4'b0000};
  endfunction

  function automatic logic decodes(input logic [31:0] w);
    return w[31:30] == 2'b00 && w[29:24] == 6'b100101 && w[23] && w[21] &&
           w[15:10] == 6'b001000 && w[3:0] == 4'b0000;
  endfunction

  function automatic logic [3:0] model_flags(input logic [31:0] w, input logic [3:0] f);
    logic [63:0] a, b;
    logic eq, t;
    a = (w[9:5] == 5'd31) ? 64'd0 : m_rf[w[9:5]];
    b = (w[20:16] == 5'd31) ? 64'd0 : m_rf[w[20:16]];
    eq = w[22] ? (a == b) : (a[31:0] == b[31:0]);
    t = w[4] ? !eq : eq;
    return t ? {1'b1, f[2], f[1], 1'b0} : {1'b0, f[2], f[1], !f[1]};
  endfunction

  task automatic check(input string req, input logic [3:0] ef, input logic eu);
    n_cmp++;
    if (flags_o !== ef || undef_o !== eu) begin
      n_bad++;
      $display("FAIL %s: flags=%b undef=%b expected flags=%b undef=%b", req, flags_o, undef_o, ef, eu);
    end
  endtask

  task automatic wr_reg(input logic [4:0] i, input logic [63:0] d);
    rf_we = 1; rf_waddr = i; rf_wdata = d;
    @(posedge clk); @(negedge clk);
    rf_we = 0;
    if (i != 5'd31) m_rf[i] = d;
  endtask

  task automatic load_flags(input logic [3:0] v);
    flag_wr = 1; flag_wdata = v;
    @(posedge clk); @(negedge clk);
    flag_wr = 0;
    m_fl = v;
    check("R10 flag load", m_fl, 1'b0);
  endtask

  task automatic issue(input string req, input logic [31:0] w, input logic en);
    logic eu;
    vec_en = en; in_valid = 1; instr = w;
    eu = !(en && decodes(w));
    if (!eu) m_fl = model_flags(w, m_fl);
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    check(req, m_fl, eu);
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    m_fl = 4'b0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R1 reset", 4'b0000, 1'b0);

    for (int i = 0; i < 31; i++) wr_reg(5'(i), {$urandom, $urandom});
    m_rf[31] = 64'd0;
    wr_reg(5'd1, 64'hDEAD_BEEF_1234_5678);
    wr_reg(5'd2, 64'h0000_0001_1234_5678);
    wr_reg(5'd3, 64'h0000_0000_0000_0000);
    wr_reg(5'd4, 64'hDEAD_BEEF_1234_5678);
    wr_reg(5'd31, 64'hFFFF_FFFF_FFFF_FFFF);

    issue("R4 eq match 64", mk(1, 0, 5'd1, 5'd4), 1);
    load_flags(4'b0110);
    issue("R5 eq fail C=1", mk(1, 0, 5'd1, 5'd2), 1);
    check("R6 Z/C kept", {1'b0, 2'b11, 1'b0}, 1'b0);
    load_flags(4'b0100);
    issue("R5 eq fail C=0", mk(1, 0, 5'd1, 5'd2), 1);
    issue("R7 32-bit ignores upper half", mk(0, 0, 5'd1, 5'd2), 1);
    issue("R4 ne differs", mk(1, 1, 5'd1, 5'd2), 1);
    issue("R8 zero register vs zero", mk(1, 0, 5'd31, 5'd3), 1);
    issue("R8 write to index 31 ignored", mk(1, 1, 5'd31, 5'd3), 1);
    issue("R2 bad opcode", mk(1, 0, 5'd1, 5'd4) | 32'h0000_0001, 1);
    issue("R3 extension disabled", mk(1, 0, 5'd1, 5'd4), 0);
    @(posedge clk); @(negedge clk);
    check("R9 idle", m_fl, 1'b0);
    wr_reg(5'd3, 64'h0000_0000_1234_5678);
    issue("R11 write then read", mk(0, 0, 5'd3, 5'd1), 1);

    flag_wr = 1; flag_wdata = 4'b0010;
    vec_en = 1; in_valid = 1; instr = mk(1, 0, 5'd1, 5'd4);
    @(posedge clk); @(negedge clk);
    flag_wr = 0; in_valid = 0; m_fl = 4'b0010;
    check("R10 load wins over instruction", m_fl, 1'b0);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) load_flags(4'($urandom));
      else if (r == 1) wr_reg(5'($urandom), {$urandom, $urandom});
      else if (r == 2) begin
        @(posedge clk); @(negedge clk);
        check("R9 random idle", m_fl, 1'b0);
      end else begin
        w = ($urandom_range(0, 7) == 0) ? $urandom
            : mk(1'($urandom), 1'($urandom), 5'($urandom), 5'($urandom));
        issue("R4/R5/R7 random", w, $urandom_range(0, 9) != 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule